// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block is the controller-side serializer of a time-slotted serial audio link. On every bit clock it moves one bit onto a single data line, and it drives a frame marker that opens each frame. A frame is a 16-bit tag slot followed by twelve data slots of `SLOT_BITS` bits each. With the default width of 20 bits a frame is 256 bit periods long. At a 12.288 MHz bit clock that gives a 48 kHz frame rate.

The parallel side offers ten audio words with their valid flags, a command address and a command data word, each with its own valid flag, and a 2-bit target codec ID. At each frame boundary the block builds the tag slot from these inputs and takes a snapshot of the whole frame. ID 00 selects the primary codec. Any other ID is a secondary access: frame-valid is forced on, both command tags are cleared, and the command address and data still travel in slots 1 and 2.

A small sequencer controls the frame. It has three states:
- `ST_IDLE` is the state held in reset. It goes to `ST_TAG` on the first edge after reset and loads a frame on that edge.
- `ST_TAG` covers the 16 tag periods, during which the marker is high. It goes to `ST_DATA` once the last tag period has been counted.
- `ST_DATA` covers the remaining periods, during which the marker is low. It goes back to `ST_TAG` on the last period of the frame and loads the next frame on that edge.

Top module: `slot_frame_tx`

## Requirements
- R1: The marker is high for exactly 16 bit periods and then low for the rest of the frame. The frame is 16 + 12·`SLOT_BITS` periods long, which is 256 by default.
- R2: The marker rises on a rising bit-clock edge. The first frame bit (tag bit 15, frame-valid) appears on the data line one bit period after the marker rises.
- R3: Bits leave in this order: tag bits 15 down to 0, then slots 1 through 12, each slot from its most significant bit down to bit 0.
- R4: Tag bit 15 (frame-valid) is 1 when any slot tag is set or when the codec ID is non-zero, and 0 otherwise.
- R5: With codec ID 00, tag bit 14 equals the command-address valid flag, tag bit 13 equals the command-data valid flag, and tag bits 1:0 are 00.
- R6: With a non-zero codec ID, tag bits 14 and 13 are 0, tag bits 1:0 carry the ID, frame-valid is 1, and slots 1 and 2 carry the command address and command data.
- R7: Tag bits 12 down to 3 carry the valid flags of slots 3 through 12 in that order. Input flag `pcm_valid_i[0]` belongs to slot 3. Tag bit 2 is always 0.
- R8: A data slot whose valid flag is clear goes out as all zeros. The same applies to slot 1 or slot 2 of a primary frame when its command tag is clear.
- R9: All parallel inputs are sampled on the edge that starts a frame. Changes made while a frame is in flight do not affect that frame.
- R10: During reset the marker and the data line are 0. The first frame starts on the first rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Incoming bit clock; the whole block runs on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pcm_data_i | input | 10·SLOT_BITS | Words for slots 3..12; slot 3 occupies the lowest word |
| pcm_valid_i | input | 10 | Valid flags for slots 3..12; bit 0 is slot 3 |
| cmd_addr_i | input | SLOT_BITS | Command address for slot 1 |
| cmd_addr_valid_i | input | 1 | Command address valid (primary access) |
| cmd_data_i | input | SLOT_BITS | Command data for slot 2 |
| cmd_data_valid_i | input | 1 | Command data valid (primary access) |
| codec_id_i | input | 2 | Target codec; 00 is primary, other values are secondary |
| sync_o | output | 1 | Frame marker |
| sdata_o | output | 1 | Serial frame data |

## Verification
The bench builds the block with `SLOT_BITS` = 4, so a frame is only 64 bit periods long. This short frame lets one run cover 48 complete frames. Across those frames the bench sweeps all four codec IDs against all four combinations of the command tags. It also varies the slot-valid patterns, including the all-clear frame and the all-set frame. Each frame's inputs are changed halfway through the frame before them, so every frame also shows that the inputs are captured at the boundary.

// File: rtl/sft_pkg.sv
package sft_pkg;
    localparam int TAG_BITS  = 16;
    localparam int NUM_SLOTS = 12;
    localparam int NUM_PCM   = 10;
    localparam int FIRST_PCM = 3;
    localparam int ID_W      = 2;

    // tag positions a receiver decodes
    localparam int TAG_FV    = 15;
    localparam int TAG_CADDR = 14;
    localparam int TAG_CDATA = 13;
    localparam int TAG_RSVD  = 2;

    typedef logic [TAG_BITS-1:0] tag_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sft_tag_builder.sv
module sft_tag_builder
    import sft_pkg::*;
(
    input  logic [NUM_PCM-1:0] pcm_valid_i,
    input  logic               addr_valid_i,
    input  logic               data_valid_i,
    input  logic [ID_W-1:0]    codec_id_i,
    output tag_t               tag_o,
    output logic               secondary_o
);
    logic sec_w;

    assign sec_w       = |codec_id_i;
    assign secondary_o = sec_w;

    // a secondary access replaces the command tags
    assign tag_o[TAG_FV]    = sec_w | addr_valid_i | data_valid_i | (|pcm_valid_i);
    assign tag_o[TAG_CADDR] = addr_valid_i & ~sec_w;
    assign tag_o[TAG_CDATA] = data_valid_i & ~sec_w;
    assign tag_o[TAG_RSVD]  = 1'b0;
    assign tag_o[ID_W-1:0]  = codec_id_i;

    for (genvar g = 0; g < NUM_PCM; g++) begin : g_pcm_tag
        assign tag_o[TAG_FV-FIRST_PCM-g] = pcm_valid_i[g];
    end
endmodule

// File: rtl/sft_frame_packer.sv
module sft_frame_packer
    import sft_pkg::*;
#(
    parameter int SLOT_BITS  = 20,
    parameter int FRAME_BITS = TAG_BITS + NUM_SLOTS*SLOT_BITS
) (
    input  tag_t                         tag_i,
    input  logic                         secondary_i,
    input  logic [NUM_PCM*SLOT_BITS-1:0] pcm_data_i,
    input  logic [NUM_PCM-1:0]           pcm_valid_i,
    input  logic [SLOT_BITS-1:0]         cmd_addr_i,
    input  logic [SLOT_BITS-1:0]         cmd_data_i,
    output logic [FRAME_BITS-1:0]        frame_o
);
    // the most significant bit leaves first
    assign frame_o[FRAME_BITS-1 -: TAG_BITS] = tag_i;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam int HI = FRAME_BITS - 1 - TAG_BITS - g*SLOT_BITS;
        if (g == 0) begin : g_addr
            assign frame_o[HI -: SLOT_BITS] =
                (tag_i[TAG_CADDR] | secondary_i) ? cmd_addr_i : '0;
        end else if (g == 1) begin : g_data
            assign frame_o[HI -: SLOT_BITS] =
                (tag_i[TAG_CDATA] | secondary_i) ? cmd_data_i : '0;
        end else begin : g_pcm
            assign frame_o[HI -: SLOT_BITS] =
                pcm_valid_i[g-2] ? pcm_data_i[(g-2)*SLOT_BITS +: SLOT_BITS] : '0;
        end
    end
endmodule

// File: rtl/sft_sequencer.sv
module sft_sequencer
    import sft_pkg::*;
#(
    parameter int FRAME_BITS = 256
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic load_o,
    output logic sync_o
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] TAG_LAST   = CNT_W'(TAG_BITS - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] pos_q, pos_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_TAG;
                pos_d   = '0;
            end
            ST_TAG: begin
                pos_d = pos_q + 1'b1;
                if (pos_q == TAG_LAST) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (pos_q == FRAME_LAST) begin
                    state_d = ST_TAG;
                    pos_d   = '0;
                end else begin
                    pos_d = pos_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                pos_d   = '0;
            end
        endcase
    end

    always_comb begin
        sync_o = (state_q == ST_TAG);
        load_o = (state_q == ST_IDLE) ||
                 ((state_q == ST_DATA) && (pos_q == FRAME_LAST));
    end
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter #(
    parameter int FRAME_BITS = 256
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  load_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    output logic                  sdata_o
);
    logic [FRAME_BITS-1:0] shreg_q;

    // one output stage so data trails the marker by a period
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shreg_q <= '0;
            sdata_o <= 1'b0;
        end else begin
            sdata_o <= shreg_q[FRAME_BITS-1];
            shreg_q <= load_i ? frame_i : {shreg_q[FRAME_BITS-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/slot_frame_tx.sv
module slot_frame_tx
    import sft_pkg::*;
#(
    parameter int SLOT_BITS = 20
) (
    input  logic                         bit_clk_i,
    input  logic                         rst_ni,
    input  logic [NUM_PCM*SLOT_BITS-1:0] pcm_data_i,
    input  logic [NUM_PCM-1:0]           pcm_valid_i,
    input  logic [SLOT_BITS-1:0]         cmd_addr_i,
    input  logic                         cmd_addr_valid_i,
    input  logic [SLOT_BITS-1:0]         cmd_data_i,
    input  logic                         cmd_data_valid_i,
    input  logic [ID_W-1:0]              codec_id_i,
    output logic                         sync_o,
    output logic                         sdata_o
);
    localparam int FRAME_BITS = TAG_BITS + NUM_SLOTS*SLOT_BITS;

    tag_t                  tag_w;
    logic                  sec_w;
    logic                  load_w;
    logic [FRAME_BITS-1:0] frame_w;

    sft_tag_builder u_tag (
        .pcm_valid_i (pcm_valid_i),
        .addr_valid_i(cmd_addr_valid_i),
        .data_valid_i(cmd_data_valid_i),
        .codec_id_i  (codec_id_i),
        .tag_o       (tag_w),
        .secondary_o (sec_w)
    );

    sft_frame_packer #(
        .SLOT_BITS (SLOT_BITS),
        .FRAME_BITS(FRAME_BITS)
    ) u_pack (
        .tag_i      (tag_w),
        .secondary_i(sec_w),
        .pcm_data_i (pcm_data_i),
        .pcm_valid_i(pcm_valid_i),
        .cmd_addr_i (cmd_addr_i),
        .cmd_data_i (cmd_data_i),
        .frame_o    (frame_w)
    );

    sft_sequencer #(
        .FRAME_BITS(FRAME_BITS)
    ) u_seq (
        .clk_i (bit_clk_i),
        .rst_ni(rst_ni),
        .load_o(load_w),
        .sync_o(sync_o)
    );

    sft_shifter #(
        .FRAME_BITS(FRAME_BITS)
    ) u_shift (
        .clk_i  (bit_clk_i),
        .rst_ni (rst_ni),
        .load_i (load_w),
        .frame_i(frame_w),
        .sdata_o(sdata_o)
    );
endmodule

// File: rtl/sft_checker.sv
module sft_checker
    import sft_pkg::*;
#(
    parameter int FRAME_BITS = 256
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            sync_i,
    input logic            sdata_i,
    input logic            load_i,
    input tag_t            tag_i,
    input logic [ID_W-1:0] codec_id_i
);
    logic [31:0] hi_run;
    logic [31:0] since_rise;
    logic        sync_prev;
    logic        seen_rise;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_run     <= '0;
            since_rise <= '0;
            sync_prev  <= 1'b0;
            seen_rise  <= 1'b0;
        end else begin
            sync_prev <= sync_i;
            hi_run    <= sync_i ? hi_run + 32'd1 : 32'd0;
            if (sync_i && !sync_prev) begin
                since_rise <= 32'd1;
                seen_rise  <= 1'b1;
            end else begin
                since_rise <= since_rise + 32'd1;
            end
        end
    end

    // R1: marker high for exactly the tag periods
    p_sync_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sync_i) |-> (hi_run == 32'(TAG_BITS)));

    // R1: marker rises once per frame length
    p_sync_period_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i && !sync_prev && seen_rise) |-> (since_rise == 32'(FRAME_BITS)));

    // R2: frame-valid bit leads the data one period after the marker
    p_lead_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> ##1 (sdata_i == $past(tag_i[TAG_FV], 2)));

    // R6: secondary access tag content
    p_secondary_tag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (codec_id_i != '0) |-> (tag_i[TAG_FV] && (tag_i[TAG_CADDR:TAG_CDATA] == 2'b00)
                                && (tag_i[ID_W-1:0] == codec_id_i)));

    // R10: every frame load raises the marker
    p_sync_on_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> $rose(sync_i));
endmodule

bind slot_frame_tx sft_checker #(
    .FRAME_BITS(FRAME_BITS)
) chk_i (
    .clk_i     (bit_clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_o),
    .sdata_i   (sdata_o),
    .load_i    (load_w),
    .tag_i     (tag_w),
    .codec_id_i(codec_id_i)
);

// File: tb/slot_frame_tx_tb_top.sv
`timescale 1ns/1ps
module slot_frame_tx_tb_top;
    localparam int DW  = 4;
    localparam int NP  = 10;
    localparam int FB  = 16 + 12*DW;
    localparam int NF  = 48;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NP*DW-1:0] pcm_data;
    logic [NP-1:0]    pcm_valid;
    logic [DW-1:0]    cmd_addr, cmd_data;
    logic             cmd_addr_v, cmd_data_v;
    logic [1:0]       codec_id;
    logic             sync_w, sdata_w;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    slot_frame_tx #(.SLOT_BITS(DW)) dut_i (
        .bit_clk_i       (clk),
        .rst_ni          (rst_n),
        .pcm_data_i      (pcm_data),
        .pcm_valid_i     (pcm_valid),
        .cmd_addr_i      (cmd_addr),
        .cmd_addr_valid_i(cmd_addr_v),
        .cmd_data_i      (cmd_data),
        .cmd_data_valid_i(cmd_data_v),
        .codec_id_i      (codec_id),
        .sync_o          (sync_w),
        .sdata_o         (sdata_w)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word(int f, int s);
        return DW'(f*7 + s*3 + 1);
    endfunction

    function automatic logic [NP-1:0] vpat(int f);
        if (f == NF-1) return '1;
        return NP'((f*173) ^ (f >> 1));
    endfunction

    // expected frame: bit FB-1 is sent first
    function automatic logic [FB-1:0] exp_frame(int f);
        logic [FB-1:0] v;
        logic [15:0]   t;
        logic [NP-1:0] vf;
        int            id, cv;
        bit            sec, en;
        id  = f % 4;
        cv  = (f / 4) % 4;
        vf  = vpat(f);
        sec = (id != 0);
        t   = '0;
        t[15] = sec || (cv != 0) || (vf != 0);
        t[14] = !sec && cv[1];
        t[13] = !sec && cv[0];
        for (int s = 3; s <= 12; s++) t[15-s] = vf[s-3];
        t[1:0] = 2'(id);
        v = '0;
        v[FB-1 -: 16] = t;
        for (int s = 1; s <= 12; s++) begin
            if (s == 1)      en = sec || cv[1];
            else if (s == 2) en = sec || cv[0];
            else             en = vf[s-3];
            if (en) v[FB-1-16-(s-1)*DW -: DW] = word(f, s);
        end
        return v;
    endfunction

    task automatic apply(int f);
        int cv;
        cv         = (f / 4) % 4;
        codec_id   = 2'(f % 4);
        cmd_addr_v = cv[1];
        cmd_data_v = cv[0];
        cmd_addr   = word(f, 1);
        cmd_data   = word(f, 2);
        for (int s = 3; s <= 12; s++) pcm_data[(s-3)*DW +: DW] = word(f, s);
        pcm_valid  = vpat(f);
    endtask

    task automatic judge(int f, logic [FB-1:0] exp, logic [FB-1:0] act);
        string lbl;
        lbl = ((f % 4) == 0) ? "R5 R4 R7 primary tag" : "R6 R4 R7 secondary tag";
        check(act[FB-1 -: 16] == exp[FB-1 -: 16], lbl,
              64'(act[FB-1 -: 16]), 64'(exp[FB-1 -: 16]));
        check(act[FB-17:0] == exp[FB-17:0], "R3 R8 R9 slot payload",
              64'(act[FB-17:0]), 64'(exp[FB-17:0]));
    endtask

    initial begin
        logic [FB-1:0] exp_cur, exp_prev, act_cur, act_prev, sync_bits, sync_exp;
        sync_exp = '0;
        sync_exp[FB-1 -: 16] = '1;
        act_cur  = '0;
        act_prev = '0;
        exp_prev = '0;
        rst_n = 1'b0;
        apply(0);
        exp_cur = exp_frame(0);
        repeat (3) @(negedge clk);
        check(sync_w == 1'b0 && sdata_w == 1'b0, "R10 reset outputs",
              64'({sync_w, sdata_w}), 64'd0);
        rst_n = 1'b1;
        for (int f = 0; f < NF; f++) begin
            for (int k = 0; k < FB; k++) begin
                @(negedge clk);
                sync_bits[FB-1-k] = sync_w;
                if (k == 0) begin
                    if (f > 0) begin
                        act_prev[0] = sdata_w;
                        judge(f-1, exp_prev, act_prev);
                    end else begin
                        check(sdata_w == 1'b0, "R10 idle bit before first frame",
                              64'(sdata_w), 64'd0);
                    end
                end else begin
                    act_cur[FB-k] = sdata_w;
                    if (k == 1)
                        check(sdata_w == exp_cur[FB-1], "R2 frame-valid leads one period",
                              64'(sdata_w), 64'(exp_cur[FB-1]));
                end
                if (k == FB/2 && f+1 < NF) apply(f+1);
            end
            check(sync_bits == sync_exp, "R1 R10 marker shape",
                  64'(sync_bits), 64'(sync_exp));
            exp_prev = exp_cur;
            act_prev = act_cur;
            exp_cur  = exp_frame(f+1);
        end
        @(negedge clk);
        act_prev[0] = sdata_w;
        judge(NF-1, exp_prev, act_prev);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected all frames done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule